// File: doc/BRIEF.md
# Predicated Store Buffer

This block queues memory stores in program order before the condition that guards each of them is known. A store is written into the next free slot as soon as it is issued, so its place in the memory order is fixed at that point. The slot index comes back as a tag. Some cycles later the pipeline resolves the guard by presenting that tag with a true or false verdict.

Stores leave from the oldest slot only. A store resolved true is offered on a valid/ready write port. A store resolved false is discarded without ever reaching memory. An oldest store that is still unresolved holds back every younger store, whether or not those are resolved. Slots are reused in a ring, so tags repeat cyclically.

Top module: `pred_store_queue`

## Requirements
- R1: After reset the buffer is empty, `enq_ready` is 1 and `mem_valid` is 0.
- R2: An enqueue is accepted on a cycle where `enq_valid` and `enq_ready` are both 1. The tag shown on `enq_tag` in that cycle is the slot index. Successive accepted stores receive tags 0, 1, …, DEPTH-1 and then wrap to 0.
- R3: With DEPTH stores held, `enq_ready` is 0 and an offered store is not stored.
- R4: While the oldest store is unresolved, `mem_valid` is 0.
- R5: When the oldest store is resolved true, `mem_valid` is 1 and `mem_addr`, `mem_data` and `mem_mask` carry that store's values. The store leaves on the cycle where `mem_ready` is 1.
- R6: When the oldest store is resolved false, it is removed one cycle after it becomes the resolved head, and `mem_valid` stays 0 during that cycle. The store never appears on the write port.
- R7: Younger stores that are resolved true are not offered while an older store is unresolved.
- R8: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_data` and `mem_mask` hold their values in the next cycle.
- R9: A resolution is ignored in three cases: its tag names a slot that holds no store, its tag names a slot being filled in the same cycle, or the store it names is already resolved.
- R10: The stores that reach memory appear in the order they were enqueued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Store offered for enqueue |
| enq_ready | output | 1 | Buffer can accept a store |
| enq_addr | input | ADDR_W | Store address |
| enq_data | input | DATA_W | Store data |
| enq_mask | input | DATA_W/8 | Byte enables of the store |
| enq_tag | output | log2(DEPTH) | Slot index given to the store accepted this cycle |
| res_valid | input | 1 | Predicate resolution present |
| res_tag | input | log2(DEPTH) | Slot whose predicate is resolved |
| res_pred | input | 1 | Resolved predicate value, 1 = perform the store |
| mem_valid | output | 1 | Write offered to memory |
| mem_ready | input | 1 | Memory takes the write |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | DATA_W | Write data |
| mem_mask | output | DATA_W/8 | Write byte enables |

## Verification
Two kinds of same-cycle event are provoked, and both are driven on a single falling edge. In the first, a write is taken from the oldest slot while a new store is enqueued, which frees a slot and fills another in one edge. In the second, a store is enqueued while a resolution arrives for the very tag it is receiving. The first case passes when the departing store is gone and the newcomer waits unresolved with the expected tag. The second passes when that resolution has no effect: the new store still blocks the write port until a later, separate resolution releases it.

// File: rtl/psq_pkg.sv
package psq_pkg;

   // Disposition of the oldest slot in the ring
   typedef enum logic [1:0] {
      HD_EMPTY = 2'd0,   // nothing held
      HD_WAIT  = 2'd1,   // guard not yet known
      HD_DROP  = 2'd2,   // guard false: discard silently
      HD_ISSUE = 2'd3    // guard true: offer to memory
   } head_state_e;

endpackage

// File: rtl/psq_ring_ctrl.sv
module psq_ring_ctrl #(
   parameter int DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic                     pop,
   output logic                     full,
   output logic [$clog2(DEPTH)-1:0] wr_ptr,
   output logic [$clog2(DEPTH)-1:0] rd_ptr
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = IDX_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign full = (count_q == CNT_MAX);

   // The ring never accepts a store into an occupied slot
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_MAX);

   // Oldest-first release: the read pointer advances only by one step
   assert_in_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> rd_ptr == IDX_W'($past(rd_ptr) + 1'b1));

endmodule

// File: rtl/psq_entry_bank.sv
module psq_entry_bank #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int MASK_W = DATA_W / 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [$clog2(DEPTH)-1:0] wr_ptr,
   input  logic [ADDR_W-1:0]        in_addr,
   input  logic [DATA_W-1:0]        in_data,
   input  logic [MASK_W-1:0]        in_mask,
   input  logic                     res_valid,
   input  logic [$clog2(DEPTH)-1:0] res_tag,
   input  logic                     res_pred,
   input  logic                     pop,
   input  logic [$clog2(DEPTH)-1:0] rd_ptr,
   output logic                     head_live,
   output logic                     head_resolved,
   output logic                     head_pred,
   output logic [ADDR_W-1:0]        head_addr,
   output logic [DATA_W-1:0]        head_data,
   output logic [MASK_W-1:0]        head_mask
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [DEPTH-1:0] live_q;
   logic [DEPTH-1:0] done_q;   // guard resolved
   logic [DEPTH-1:0] pred_q;   // guard value once resolved
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [MASK_W-1:0] mask_q [DEPTH];

   // Per-slot control state; a fill takes priority, a fresh slot
   // cannot be resolved in its own fill cycle, and a resolved slot
   // keeps its first verdict
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
         done_q <= '0;
         pred_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (push && wr_ptr == IDX_W'(i)) begin
               live_q[i] <= 1'b1;
               done_q[i] <= 1'b0;
               pred_q[i] <= 1'b0;
            end else if (pop && rd_ptr == IDX_W'(i)) begin
               live_q[i] <= 1'b0;
               done_q[i] <= 1'b0;
               pred_q[i] <= 1'b0;
            end else if (res_valid && res_tag == IDX_W'(i) && live_q[i] && !done_q[i]) begin
               done_q[i] <= 1'b1;
               pred_q[i] <= res_pred;
            end
         end
      end
   end

   // Payload needs no reset: it is only read behind a live slot
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push && wr_ptr == IDX_W'(i)) begin
            addr_q[i] <= in_addr;
            data_q[i] <= in_data;
            mask_q[i] <= in_mask;
         end
      end
   end

   assign head_live     = live_q[rd_ptr];
   assign head_resolved = done_q[rd_ptr];
   assign head_pred     = pred_q[rd_ptr];
   assign head_addr     = addr_q[rd_ptr];
   assign head_data     = data_q[rd_ptr];
   assign head_mask     = mask_q[rd_ptr];

   // A held verdict never changes before the slot leaves
   assert_verdict_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (head_live && head_resolved && !pop) |=> (head_resolved && $stable(head_pred)));

   // A freshly filled slot comes up unresolved
   assert_fill_unresolved_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !head_live) |=> (head_live && !head_resolved));

endmodule

// File: rtl/psq_drain_port.sv
module psq_drain_port
   import psq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int MASK_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_live,
   input  logic              head_resolved,
   input  logic              head_pred,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [DATA_W-1:0] head_data,
   input  logic [MASK_W-1:0] head_mask,
   input  logic              mem_ready,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic [MASK_W-1:0] mem_mask,
   output logic              pop
);
   head_state_e hstate;

   always_comb begin
      if (!head_live)          hstate = HD_EMPTY;
      else if (!head_resolved) hstate = HD_WAIT;
      else if (!head_pred)     hstate = HD_DROP;
      else                     hstate = HD_ISSUE;
   end

   assign mem_valid = (hstate == HD_ISSUE);
   assign pop       = (hstate == HD_DROP) || ((hstate == HD_ISSUE) && mem_ready);
   assign mem_addr  = head_addr;
   assign mem_data  = head_data;
   assign mem_mask  = head_mask;

   // Write port holds its offer while memory stalls
   assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=>
         (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_mask)));

   // A discarded store leaves without a write strobe
   assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (head_live && head_resolved && !head_pred) |-> (pop && !mem_valid));

   // Nothing leaves while the oldest guard is open
   assert_wait_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (head_live && !head_resolved) |-> (!pop && !mem_valid));

endmodule

// File: rtl/pred_store_queue.sv
module pred_store_queue #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enq_valid,
   output logic                     enq_ready,
   input  logic [ADDR_W-1:0]        enq_addr,
   input  logic [DATA_W-1:0]        enq_data,
   input  logic [DATA_W/8-1:0]      enq_mask,
   output logic [$clog2(DEPTH)-1:0] enq_tag,
   input  logic                     res_valid,
   input  logic [$clog2(DEPTH)-1:0] res_tag,
   input  logic                     res_pred,
   output logic                     mem_valid,
   input  logic                     mem_ready,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [DATA_W-1:0]        mem_data,
   output logic [DATA_W/8-1:0]      mem_mask
);
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int MASK_W = DATA_W / 8;

   // Elaboration-time parameter checks
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("pred_store_queue: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("pred_store_queue: DATA_W must be a whole number of bytes");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("pred_store_queue: ADDR_W must be positive");
   end

   logic             full;
   logic             push;
   logic             pop;
   logic [IDX_W-1:0] wr_ptr;
   logic [IDX_W-1:0] rd_ptr;
   logic             head_live;
   logic             head_resolved;
   logic             head_pred;
   logic [ADDR_W-1:0] head_addr;
   logic [DATA_W-1:0] head_data;
   logic [MASK_W-1:0] head_mask;

   assign enq_ready = !full;
   assign push      = enq_valid && !full;
   assign enq_tag   = wr_ptr;

   psq_ring_ctrl #(.DEPTH(DEPTH)) ring_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push),
      .pop    (pop),
      .full   (full),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr)
   );

   psq_entry_bank #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MASK_W (MASK_W)
   ) bank_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .push          (push),
      .wr_ptr        (wr_ptr),
      .in_addr       (enq_addr),
      .in_data       (enq_data),
      .in_mask       (enq_mask),
      .res_valid     (res_valid),
      .res_tag       (res_tag),
      .res_pred      (res_pred),
      .pop           (pop),
      .rd_ptr        (rd_ptr),
      .head_live     (head_live),
      .head_resolved (head_resolved),
      .head_pred     (head_pred),
      .head_addr     (head_addr),
      .head_data     (head_data),
      .head_mask     (head_mask)
   );

   psq_drain_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MASK_W (MASK_W)
   ) drain_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .head_live     (head_live),
      .head_resolved (head_resolved),
      .head_pred     (head_pred),
      .head_addr     (head_addr),
      .head_data     (head_data),
      .head_mask     (head_mask),
      .mem_ready     (mem_ready),
      .mem_valid     (mem_valid),
      .mem_addr      (mem_addr),
      .mem_data      (mem_data),
      .mem_mask      (mem_mask),
      .pop           (pop)
   );

   // Reset leaves the buffer accepting and silent
   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (enq_ready && !mem_valid));

endmodule

// File: tb/pred_store_queue_tb_top.sv
module pred_store_queue_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int DEPTH  = 8;
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int MASK_W = DATA_W / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enq_valid = 1'b0;
   logic enq_ready;
   logic [ADDR_W-1:0] enq_addr = '0;
   logic [DATA_W-1:0] enq_data = '0;
   logic [MASK_W-1:0] enq_mask = '0;
   logic [IDX_W-1:0]  enq_tag;
   logic res_valid = 1'b0;
   logic [IDX_W-1:0] res_tag = '0;
   logic res_pred = 1'b0;
   logic mem_valid;
   logic mem_ready = 1'b0;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_data;
   logic [MASK_W-1:0] mem_mask;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;
   logic [IDX_W-1:0] next_tag = '0;   // bench's own view of slot allocation

   always #(CLK_PERIOD/2) clk = ~clk;

   pred_store_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_ready(enq_ready),
      .enq_addr(enq_addr), .enq_data(enq_data), .enq_mask(enq_mask),
      .enq_tag(enq_tag),
      .res_valid(res_valid), .res_tag(res_tag), .res_pred(res_pred),
      .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_data(mem_data), .mem_mask(mem_mask)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   // Offer one store; checks readiness and the returned tag
   task automatic push_store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                             input logic [MASK_W-1:0] m);
      @(negedge clk);
      enq_valid = 1'b1; enq_addr = a; enq_data = d; enq_mask = m;
      check("R2", "enq_ready before accept", 64'(enq_ready), 64'(1));
      check("R2", "enq_tag", 64'(enq_tag), 64'(next_tag));
      next_tag = next_tag + 1'b1;
      @(posedge clk); #1;
      enq_valid = 1'b0;
   endtask

   task automatic resolve(input logic [IDX_W-1:0] t, input logic p);
      @(negedge clk);
      res_valid = 1'b1; res_tag = t; res_pred = p;
      @(posedge clk); #1;
      res_valid = 1'b0;
   endtask

   // Waits briefly for an offer, then checks and accepts it
   task automatic take_write(input string req, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, input logic [MASK_W-1:0] m);
      @(negedge clk);
      for (int k = 0; k < 3 && !mem_valid; k++) @(negedge clk);
      check(req, "mem_valid", 64'(mem_valid), 64'(1));
      check(req, "mem_addr", 64'(mem_addr), 64'(a));
      check(req, "mem_data", 64'(mem_data), 64'(d));
      check(req, "mem_mask", 64'(mem_mask), 64'(m));
      mem_ready = 1'b1;
      @(posedge clk); #1;
      mem_ready = 1'b0;
   endtask

   task automatic expect_quiet(input string req, input int cycles);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         check(req, "mem_valid idle", 64'(mem_valid), 64'(0));
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      next_tag = '0;
      @(negedge clk);
      check("R1", "enq_ready after reset", 64'(enq_ready), 64'(1));
      check("R1", "mem_valid after reset", 64'(mem_valid), 64'(0));
   endtask

   // Blocking head, one-cycle drop, stalled hold
   task automatic t_basic();
      logic [IDX_W-1:0] t0;
      t0 = next_tag;
      push_store(32'hA000_0000, 32'h1111_0000, 4'hF);
      push_store(32'hA000_0004, 32'h2222_0001, 4'h3);
      push_store(32'hA000_0008, 32'h3333_0002, 4'hC);
      expect_quiet("R4", 2);
      resolve(t0 + 2'd1, 1'b1);
      resolve(t0 + 2'd2, 1'b1);
      expect_quiet("R7", 2);
      resolve(t0, 1'b0);
      @(negedge clk);
      check("R6", "no strobe while dropping", 64'(mem_valid), 64'(0));
      @(negedge clk);
      check("R6", "next store offered one cycle later", 64'(mem_valid), 64'(1));
      check("R6", "dropped store not shown", 64'(mem_addr), 64'(32'hA000_0004));
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R8", "valid held", 64'(mem_valid), 64'(1));
         check("R8", "addr held", 64'(mem_addr), 64'(32'hA000_0004));
         check("R8", "data held", 64'(mem_data), 64'(32'h2222_0001));
         check("R8", "mask held", 64'(mem_mask), 64'(4'h3));
      end
      take_write("R5", 32'hA000_0004, 32'h2222_0001, 4'h3);
      take_write("R5", 32'hA000_0008, 32'h3333_0002, 4'hC);
      expect_quiet("R5", 2);
   endtask

   // Fill to capacity, refuse one more, release out of order, drain in order
   task automatic t_full();
      logic [IDX_W-1:0] base;
      base = next_tag;
      for (int i = 0; i < DEPTH; i++)
         push_store(32'hB000_0000 + 32'(i * 4), 32'hD000_0000 + 32'(i), 4'(i + 1));
      @(negedge clk);
      check("R3", "enq_ready when full", 64'(enq_ready), 64'(0));
      enq_valid = 1'b1; enq_addr = 32'hDEAD_BEEF; enq_data = 32'hBAD0_BAD0; enq_mask = 4'hF;
      @(posedge clk); #1;
      enq_valid = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--)
         resolve(base + IDX_W'(i), (i != 4));
      for (int i = 0; i < DEPTH; i++)
         if (i != 4)
            take_write("R10", 32'hB000_0000 + 32'(i * 4), 32'hD000_0000 + 32'(i), 4'(i + 1));
      expect_quiet("R3", 3);
   endtask

   // Resolutions that must have no effect
   task automatic t_ignored();
      logic [IDX_W-1:0] t0;
      t0 = next_tag;
      resolve(t0 + 1'b1, 1'b1);                 // slot not yet holding a store
      push_store(32'hC000_0010, 32'h5555_AAAA, 4'h1);
      push_store(32'hC000_0014, 32'h6666_BBBB, 4'h2);
      resolve(t0, 1'b1);
      resolve(t0, 1'b0);                        // already resolved true
      @(negedge clk);
      check("R9", "re-resolve left store offered", 64'(mem_valid), 64'(1));
      take_write("R9", 32'hC000_0010, 32'h5555_AAAA, 4'h1);
      expect_quiet("R9", 3);                    // early resolution was ignored
      resolve(t0 + 1'b1, 1'b1);
      take_write("R9", 32'hC000_0014, 32'h6666_BBBB, 4'h2);
   endtask

   // Same-cycle enqueue with drain, and with a resolution of its own tag
   task automatic t_concurrent();
      logic [IDX_W-1:0] t0;
      t0 = next_tag;
      push_store(32'hE000_0000, 32'h0000_00E0, 4'hF);
      resolve(t0, 1'b1);
      @(negedge clk);
      check("R5", "offer before overlap", 64'(mem_valid), 64'(1));
      mem_ready = 1'b1;
      enq_valid = 1'b1; enq_addr = 32'hE000_0004; enq_data = 32'h0000_00E1; enq_mask = 4'h7;
      check("R2", "tag during drain", 64'(enq_tag), 64'(t0 + 1'b1));
      @(posedge clk); #1;
      mem_ready = 1'b0; enq_valid = 1'b0;
      expect_quiet("R4", 2);
      @(negedge clk);
      enq_valid = 1'b1; enq_addr = 32'hE000_0008; enq_data = 32'h0000_00E2; enq_mask = 4'h8;
      res_valid = 1'b1; res_tag = t0 + 2'd2; res_pred = 1'b1;   // tag being filled now
      check("R2", "tag with clashing resolve", 64'(enq_tag), 64'(t0 + 2'd2));
      @(posedge clk); #1;
      enq_valid = 1'b0; res_valid = 1'b0;
      next_tag = t0 + 2'd3;
      resolve(t0 + 1'b1, 1'b1);
      take_write("R10", 32'hE000_0004, 32'h0000_00E1, 4'h7);
      expect_quiet("R9", 3);                    // same-cycle resolve ignored
      resolve(t0 + 2'd2, 1'b0);
      expect_quiet("R6", 3);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_full();
      t_ignored();
      t_concurrent();
      repeat (2) @(negedge clk);
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      summary();
   end

endmodule